// File: doc/BRIEF.md
# Three-Channel Pausable PWM Generator

The block produces three pulse-width-modulated outputs that all run off a single shared period counter. Software programs one period value and a separate compare (duty) value for each channel. It then starts or stops all three channels together through one control word. Each output is high for as many clock cycles per period as its duty value, capped at the full period.

All three channels can be frozen at once in either of two ways. One is a software pause bit. The other is an external hardware pause request, which only takes effect while a permit bit in the control word is set. While frozen, the counter and every output hold where they are, and counting picks up again from the held value. Period and duty values written by software are staged and applied only when the counter wraps, so no period is ever cut short or stretched mid-way.

The register port is a plain strobe interface: one write strobe with address and data, and one read strobe whose data appears on the following cycle. The hardware pause input is assumed to be synchronous to the block clock.

Top module: `tri_pwm`

## Requirements
- R1: After reset the control register reads 0x0004 (bit 2 set, bits 1 and 0 clear). The period and all three duty registers read 0, and all outputs are low.
- R2: While enabled and not paused, the shared counter steps by one each cycle from 0 up to the active period value P, then returns to 0, so one period lasts P+1 cycles.
- R3: While enabled, output channel i is high exactly while the counter is below that channel's active duty value. A duty of 0 keeps the channel low, and a duty above P keeps it high.
- R4: Control bit 0 enables all channels. While it is clear, the counter is held at 0 and all outputs are low. When it is set, counting starts from 0 using the most recently written period and duty values.
- R5: While control bit 1 (software pause) is set, the counter and all outputs hold their values. After the bit is cleared, counting continues from the held value.
- R6: While control bit 2 is set, a high level on hw_pause_req pauses the block exactly as R5 does. While bit 2 is clear, hw_pause_req has no effect on the counter or the outputs.
- R7: A period or duty value written while the block is enabled takes effect only at the next counter wrap (counter equal to P, not paused). Until then the running period continues unchanged.
- R8: The register map is: address 0 control (bits 2:0), address 1 period (bits 13:0), and addresses 2, 3 and 4 the duty of channels 0, 1 and 2 (bits 13:0). A read strobe returns the stored value, with unused upper bits as 0, on rdata in the next cycle; rdata holds otherwise. Addresses 5 to 7 read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| hw_pause_req | input | 1 | External pause request, honoured only when permitted |
| pwm_out | output | 3 | PWM outputs, channel 0 in bit 0 |

## Verification
Four properties are checked on every cycle: the counter never passes the active period, a disabled block clears the counter, a pause from either source freezes the counter, and the active period and duty values change only at a wrap or while disabled. Whether an ignored hardware request really lets the count advance is also checked every cycle, along with the disabled outputs being low. Only the bench's scenarios show the actual waveform shapes for the edge duties (zero and above the period), the exact cycle at which a mid-period write becomes visible, and resuming from a held count. They also cover register readback, including truncated upper bits and the unmapped addresses.

// File: rtl/tri_pwm.sv
module tri_pwm #(
  parameter int CNT_W  = 14,
  parameter int NUM_CH = 3,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              hw_pause_req,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int CTRL_W = 3;
  localparam logic [CTRL_W-1:0] CTRL_RST = 3'b100;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(1);
  localparam int DUTY_BASE = 2;

  logic [CTRL_W-1:0] ctrl_q;
  logic [CNT_W-1:0]  per_q, per_act, cnt_q;
  logic [NUM_CH*CNT_W-1:0] duty_q_flat, duty_act_flat;
  logic [DATA_W-1:0] rd_mux;

  wire run_en   = ctrl_q[0];
  wire sw_pause = ctrl_q[1];
  wire hw_allow = ctrl_q[2];
  wire paused   = sw_pause | (hw_allow & hw_pause_req);
  wire at_wrap  = cnt_q >= per_act;
  wire load_act = !run_en || (!paused && at_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      per_q  <= '0;
    end else if (wr_en) begin
      if (addr == A_CTRL) ctrl_q <= wdata[CTRL_W-1:0];
      if (addr == A_PER)  per_q  <= wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      per_act <= '0;
    end else begin
      if (!run_en)       cnt_q <= '0;
      else if (!paused)  cnt_q <= at_wrap ? '0 : cnt_q + 1'b1;
      if (load_act)      per_act <= per_q;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(DUTY_BASE + i);
    logic [CNT_W-1:0] duty_q, duty_act;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       duty_q <= '0;
      else if (wr_en && addr == A_DUTY) duty_q <= wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        duty_act <= '0;
      else if (load_act) duty_act <= duty_q;
    end

    assign duty_q_flat[i*CNT_W +: CNT_W]   = duty_q;
    assign duty_act_flat[i*CNT_W +: CNT_W] = duty_act;
    assign pwm_out[i] = run_en && (cnt_q < duty_act);
  end

  always_comb begin
    rd_mux = '0;
    if (addr == A_CTRL) rd_mux = DATA_W'(ctrl_q);
    if (addr == A_PER)  rd_mux = DATA_W'(per_q);
    for (int i = 0; i < NUM_CH; i++)
      if (addr == ADDR_W'(DUTY_BASE + i)) rd_mux = DATA_W'(duty_q_flat[i*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/tri_pwm_chk.sv
module tri_pwm_chk #(
  parameter int CNT_W  = 14,
  parameter int NUM_CH = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    run_en,
  input logic                    sw_pause,
  input logic                    hw_allow,
  input logic                    hw_pause_req,
  input logic                    paused,
  input logic [CNT_W-1:0]        cnt_q,
  input logic [CNT_W-1:0]        per_act,
  input logic [NUM_CH*CNT_W-1:0] duty_act_flat,
  input logic [NUM_CH-1:0]       pwm_out
);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> cnt_q <= per_act); // R2

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> cnt_q == '0); // R4

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> pwm_out == '0); // R4

  AST_SW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && sw_pause) |=> $stable(cnt_q)); // R5

  AST_HW_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && hw_allow && hw_pause_req) |=> $stable(cnt_q)); // R6

  AST_HW_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !hw_allow && !sw_pause && hw_pause_req && cnt_q < per_act)
      |=> cnt_q == $past(cnt_q) + 1'b1); // R6

  AST_STAGED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && (paused || cnt_q < per_act)) |=> ($stable(per_act) && $stable(duty_act_flat))); // R7

endmodule

bind tri_pwm tri_pwm_chk #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .sw_pause(sw_pause),
  .hw_allow(hw_allow), .hw_pause_req(hw_pause_req), .paused(paused),
  .cnt_q(cnt_q), .per_act(per_act), .duty_act_flat(duty_act_flat),
  .pwm_out(pwm_out)
);

// File: tb/test_tri_pwm.sv
`timescale 1ns/1ps
module test_tri_pwm;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0, hw_pause_req = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  pwm_out;

  int vectors = 0, miscompares = 0;
  string cur_req = "R1";
  bit done = 0;

  always #10 clk = ~clk;

  tri_pwm i_tri_pwm (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .hw_pause_req(hw_pause_req),
    .pwm_out(pwm_out));

  int m_ctrl, m_per, m_cnt, m_aper, m_rd;
  int m_duty[3], m_aduty[3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 4; m_per = 0; m_cnt = 0; m_aper = 0; m_rd = 0;
      foreach (m_duty[i]) begin m_duty[i] = 0; m_aduty[i] = 0; end
    end else begin
      bit en, hold, reload;
      en = m_ctrl[0];
      hold = m_ctrl[1] || (m_ctrl[2] && hw_pause_req);
      reload = !en || (!hold && m_cnt == m_aper);
      if (!en) m_cnt = 0;
      else if (!hold) m_cnt = (m_cnt == m_aper) ? 0 : m_cnt + 1;
      if (reload) begin
        m_aper = m_per;
        foreach (m_aduty[i]) m_aduty[i] = m_duty[i];
      end
      if (rd_en) begin
        case (addr)
          0: m_rd = m_ctrl;
          1: m_rd = m_per;
          2, 3, 4: m_rd = m_duty[addr-2];
          default: m_rd = 0;
        endcase
      end
      if (wr_en) begin
        case (addr)
          0: m_ctrl = wdata & 16'h7;
          1: m_per = wdata & 16'h3fff;
          2, 3, 4: m_duty[addr-2] = wdata & 16'h3fff;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [2:0] exp_pwm();
    logic [2:0] e;
    for (int i = 0; i < 3; i++) e[i] = m_ctrl[0] && (m_cnt < m_aduty[i]);
    return e;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (pwm_out !== exp_pwm() || rdata !== 16'(m_rd)) begin
        miscompares++;
        $display("FAIL %s t=%0t pwm=%b rdata=%h expected pwm=%b rdata=%h",
                 cur_req, $time, pwm_out, rdata, exp_pwm(), 16'(m_rd));
      end
    end
  end

  task automatic idle(int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_check(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    vectors++;
    if (rdata !== exp) begin
      miscompares++;
      $display("FAIL %s read addr %0d actual=%h expected=%h", req, a, rdata, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    cur_req = "R1";
    vectors++;
    if (pwm_out !== 3'b000) begin
      miscompares++;
      $display("FAIL R1 pwm actual=%b expected=000", pwm_out);
    end
    rd_check(0, 16'h0004, "R1");
    rd_check(1, 16'h0000, "R1");
    for (int i = 2; i < 5; i++) rd_check(3'(i), 16'h0000, "R1");

    cur_req = "R8";
    wr(1, 16'd9);
    wr(2, 16'd3);
    wr(3, 16'd7);
    wr(4, 16'hC00C);
    rd_check(4, 16'h000C, "R8");
    wr(7, 16'h1234);
    rd_check(7, 16'h0000, "R8");
    rd_check(5, 16'h0000, "R8");
    rd_check(1, 16'd9, "R8");

    cur_req = "R4";
    idle(3);
    wr(0, 16'h0005);
    cur_req = "R2";
    idle(25);
    cur_req = "R3";
    wr(2, 16'd0);
    idle(22);

    cur_req = "R5";
    wr(0, 16'h0007);
    idle(6);
    wr(0, 16'h0005);
    idle(13);

    cur_req = "R6";
    hw_pause_req = 1'b1;
    idle(7);
    hw_pause_req = 1'b0;
    idle(4);
    wr(0, 16'h0001);
    hw_pause_req = 1'b1;
    idle(15);
    hw_pause_req = 1'b0;

    cur_req = "R7";
    wr(1, 16'd4);
    wr(3, 16'd2);
    idle(20);
    wr(1, 16'd15);
    wr(2, 16'd15);
    idle(40);

    cur_req = "R4";
    wr(0, 16'h0000);
    idle(8);
    wr(0, 16'h0001);
    idle(10);
    rd_check(0, 16'h0001, "R8");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule